// File: doc/BRIEF.md
# Infrared pulse-width symbol decoder

This block turns the demodulated output of an infrared receiver into message bits. The input is synchronised to the system clock and its polarity is optionally corrected. The decoder then measures each active pulse and the idle gap after it in clock cycles. Each pulse/gap pair is checked against a bank of programmable windows. One window is for a leader symbol and four are for data symbols. A pair is accepted only when both its pulse width and its total period (pulse plus gap) fall inside the window of one symbol.

Data symbols give one bit each. The first window pair gives 0 and 1. The second pair is an alternate timing set that also gives 0 and 1. Bits go into a 64-bit shift register, filling from either end. A message ends when the line has been idle for longer than a programmable free time. At that point the bit count is checked against programmable minimum and maximum lengths. A message that passes copies its data and length into readable registers and raises a sticky valid flag, which software clears. Software programs the block and reads results through a simple word-addressed register port.

Top module: `ir_pulse_decoder`

## Requirements
- R1: After reset every register reads zero: control, status, data low and high words, all timing windows and the frame register. `data_valid` is low.
- R2: Each timing word at addresses 2 to 6 holds width minimum in bits [7:0], width maximum in [15:8], period minimum in [23:16] and period maximum in [31:24]. Address 2 is the leader, 3 data 0, 4 data 1, 5 alternate 0, 6 alternate 1. The leader compares width and period in units of 16 clocks. Data symbols compare width in single clocks and period in units of 2 clocks. A message of correct symbols is received, with its bit count in status [14:8] and its bits in data words at addresses 8 (bits 31:0) and 9 (bits 63:32).
- R3: Control bit 2 selects the fill order. When it is 1, the first received bit lands in data bit 0 and later bits go to higher positions. When it is 0, each new bit is shifted in at bit 0, so the last received bit sits at bit 0.
- R4: Control bit 3 inverts every received data bit before it is stored.
- R5: Control bit 1 makes the input active-low. Pulses are then low levels on `ir_in`.
- R6: The alternate data windows decode to bit 0 (address 5) and bit 1 (address 6). Windows are tried in the order data 0, data 1, alternate 0, alternate 1.
- R7: A pair whose width or period fits no window discards the whole message, and `data_valid` is not set. The next message that starts after the line goes idle is decoded normally.
- R8: At message end the bit count must lie between the minimum length and the maximum length, both inclusive, or the message is discarded.
- R9: The frame register (address 7) holds minimum length in [4:0], maximum length in [13:8] and free time in [28:16]. A written minimum is rounded down to even and capped at 30. A written maximum is rounded up to even and capped at 48.
- R10: With control bit 4 (leader required) set, the first pair must match the leader window or the message is discarded. With it clear, the first pair is decoded as data.
- R11: The valid flag (status bit 0 and `data_valid`) stays set until a write to status (address 1) with bit 0 at 0. Writing 1 there never sets it.
- R12: Control bit 0 enables decoding. While it is 0, the decoder stays idle and no message becomes valid.
- R13: A message ends only once the line has stayed idle for more than free time × 8 clocks after the last pulse. Valid rises a few cycles after that, the delay being the synchroniser latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Asynchronous demodulated infrared line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| data_valid | output | 1 | Sticky valid flag for a received message |

## Verification
A wrong receive state shows up in one of two ways: a message that never turns valid, or one that turns valid with the wrong length or data. That error appears at the ports as soon as the free-time gap after the final pulse has run out, roughly free time × 8 clocks plus the synchroniser delay. Misclassified symbols shift wrong or extra bits into the data words, and that is visible when the words are read back after the valid flag rises. Idle-timing faults move the cycle in which `data_valid` rises, so the bench checks it both just before and just after the free-time window.

// File: rtl/ir_dec_pkg.sv
package ir_dec_pkg;

   localparam int REG_W   = 32;
   localparam int WFIELD_W = 8;

   // Register word addresses; the window addresses are consecutive.
   localparam int A_CTRL  = 0;
   localparam int A_STAT  = 1;
   localparam int A_WIN0  = 2;
   localparam int A_FRAME = 7;
   localparam int A_DLO   = 8;
   localparam int A_DHI   = 9;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_SPACE = 2'd2
   } rx_state_t;

   typedef struct packed {
      logic [WFIELD_W-1:0] pd_max;
      logic [WFIELD_W-1:0] pd_min;
      logic [WFIELD_W-1:0] w_max;
      logic [WFIELD_W-1:0] w_min;
   } sym_win_t;

   typedef struct packed {
      logic ldr_en;
      logic bit_inv;
      logic lsb_first;
      logic pol_inv;
      logic run;
   } ctrl_t;

endpackage

// File: rtl/ir_sync_edge.sv
module ir_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   input  logic pol_inv,
   output logic act,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ir_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              act_prev;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= raw;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= 1'b0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign act = chain[STAGES-1] ^ pol_inv;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) act_prev <= 1'b0;
      else        act_prev <= act;

   assign rise = act & ~act_prev;
endmodule

// File: rtl/ir_win_match.sv
module ir_win_match
   import ir_dec_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int W_SHIFT = 0,
   parameter int P_SHIFT = 1
) (
   input  logic [CNT_W-1:0] width,
   input  logic [CNT_W:0]   period,
   input  sym_win_t         win,
   output logic             hit
);
   if (CNT_W < WFIELD_W) begin : g_bad_cnt
      $error("ir_win_match: CNT_W narrower than a window field");
   end

   logic [CNT_W-1:0] w_s;
   logic [CNT_W:0]   p_s;
   logic             w_ok, p_ok;

   assign w_s  = width  >> W_SHIFT;
   assign p_s  = period >> P_SHIFT;
   assign w_ok = (w_s >= CNT_W'(win.w_min)) && (w_s <= CNT_W'(win.w_max));
   assign p_ok = (p_s >= (CNT_W+1)'(win.pd_min)) && (p_s <= (CNT_W+1)'(win.pd_max));
   assign hit  = w_ok && p_ok;
endmodule

// File: rtl/ir_dec_regs.sv
module ir_dec_regs
   import ir_dec_pkg::*;
#(
   parameter int LEN_W      = 7,
   parameter int FT_W       = 13,
   parameter int MINLEN_CAP = 30,
   parameter int MAXLEN_CAP = 48,
   parameter int NUM_WIN    = 5,
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output ctrl_t             ctrl,
   output sym_win_t          win [NUM_WIN],
   output logic [LEN_W-1:0]  minlen,
   output logic [LEN_W-1:0]  maxlen,
   output logic [FT_W-1:0]   ft_min,
   input  logic              msg_ok,
   input  logic [LEN_W-1:0]  msg_len,
   input  logic [DATA_W-1:0] msg_data,
   output logic              valid,
   output logic [LEN_W-1:0]  stat_len
);
   localparam int MINF_W = 5;
   localparam int MAXF_W = 6;

   if (DATA_W != 2*REG_W) begin : g_bad_data
      $error("ir_dec_regs: data must be two register words");
   end
   if ((MINLEN_CAP % 2) != 0 || MINLEN_CAP >= (1 << MINF_W)) begin : g_bad_min
      $error("ir_dec_regs: MINLEN_CAP must be even and fit its field");
   end
   if ((MAXLEN_CAP % 2) != 0 || MAXLEN_CAP >= (1 << MAXF_W) || MAXLEN_CAP > DATA_W) begin : g_bad_max
      $error("ir_dec_regs: MAXLEN_CAP must be even and fit its field");
   end
   if (LEN_W < MAXF_W + 1 || LEN_W > 8) begin : g_bad_len
      $error("ir_dec_regs: LEN_W out of range");
   end
   if (FT_W > 16) begin : g_bad_ft
      $error("ir_dec_regs: FT_W must fit bits 31:16");
   end

   ctrl_t               ctrl_q;
   sym_win_t            win_q [NUM_WIN];
   logic [MINF_W-1:0]   minf_q, minf_d;
   logic [MAXF_W-1:0]   maxf_q, maxf_d;
   logic [FT_W-1:0]     ft_q;
   logic                valid_q;
   logic [LEN_W-1:0]    len_q;
   logic [DATA_W-1:0]   data_q;
   logic [MINF_W-1:0]   min_raw;
   logic [MAXF_W-1:0]   max_raw;
   logic                sel_ctrl, sel_stat, sel_frame;

   assign sel_ctrl  = wr && (addr == ADDR_W'(A_CTRL));
   assign sel_stat  = wr && (addr == ADDR_W'(A_STAT));
   assign sel_frame = wr && (addr == ADDR_W'(A_FRAME));

   // Length fields are normalised on write: minimum down to even, maximum up.
   assign min_raw = wdata[MINF_W-1:0];
   assign max_raw = wdata[8 +: MAXF_W];
   assign minf_d  = (min_raw > MINF_W'(MINLEN_CAP)) ? MINF_W'(MINLEN_CAP)
                                                    : {min_raw[MINF_W-1:1], 1'b0};
   assign maxf_d  = (max_raw >= MAXF_W'(MAXLEN_CAP)) ? MAXF_W'(MAXLEN_CAP)
                                                     : MAXF_W'(((MAXF_W+1)'(max_raw) + (MAXF_W+1)'(1))
                                                               & ~(MAXF_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         minf_q <= '0;
         maxf_q <= '0;
         ft_q   <= '0;
      end else begin
         if (sel_ctrl) ctrl_q <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
         if (sel_frame) begin
            minf_q <= minf_d;
            maxf_q <= maxf_d;
            ft_q   <= wdata[16 +: FT_W];
         end
      end
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n)
         if (!rst_n)                                      win_q[i] <= '0;
         else if (wr && (addr == ADDR_W'(A_WIN0 + i)))    win_q[i] <= sym_win_t'(wdata);
      assign win[i] = win_q[i];
   end

   // Result capture: a finished message wins over a same-cycle status write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         len_q   <= '0;
         data_q  <= '0;
      end else if (msg_ok) begin
         valid_q <= 1'b1;
         len_q   <= msg_len;
         data_q  <= msg_data;
      end else if (sel_stat) begin
         valid_q <= valid_q & wdata[0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(A_CTRL)) begin
         rdata[$bits(ctrl_t)-1:0] = ctrl_q;
      end else if (addr == ADDR_W'(A_STAT)) begin
         rdata[0]          = valid_q;
         rdata[8 +: LEN_W] = len_q;
      end else if (addr == ADDR_W'(A_FRAME)) begin
         rdata[MINF_W-1:0] = minf_q;
         rdata[8 +: MAXF_W] = maxf_q;
         rdata[16 +: FT_W]  = ft_q;
      end else if (addr == ADDR_W'(A_DLO)) begin
         rdata = data_q[REG_W-1:0];
      end else if (addr == ADDR_W'(A_DHI)) begin
         rdata = data_q[DATA_W-1:REG_W];
      end
      for (int i = 0; i < NUM_WIN; i++)
         if (addr == ADDR_W'(A_WIN0 + i)) rdata = win_q[i];
   end

   assign ctrl     = ctrl_q;
   assign minlen   = LEN_W'(minf_q);
   assign maxlen   = LEN_W'(maxf_q);
   assign ft_min   = ft_q;
   assign valid    = valid_q;
   assign stat_len = len_q;
endmodule

// File: rtl/ir_pulse_decoder.sv
module ir_pulse_decoder
   import ir_dec_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int FT_W         = 13,
   parameter int LEN_W        = 7,
   parameter int SYNC_STAGES  = 2,
   parameter int LDR_SHIFT    = 4,
   parameter int DAT_PD_SHIFT = 1,
   parameter int DAT_W_SHIFT  = 0,
   parameter int FT_SHIFT     = 3,
   parameter int MINLEN_CAP   = 30,
   parameter int MAXLEN_CAP   = 48
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ir_in,
   input  logic        reg_wr,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        data_valid
);
   localparam int DATA_W  = 64;
   localparam int NUM_WIN = 5;
   localparam int ADDR_W  = 4;
   localparam int IDX_W   = $clog2(DATA_W);
   localparam int THR_W   = FT_W + FT_SHIFT;

   if (CNT_W < THR_W) begin : g_bad_thr
      $error("ir_pulse_decoder: space counter cannot reach the free-time limit");
   end
   if (LEN_W <= IDX_W) begin : g_bad_len
      $error("ir_pulse_decoder: LEN_W too narrow to count a full register");
   end

   ctrl_t             ctrl;
   sym_win_t          win [NUM_WIN];
   logic [LEN_W-1:0]  minlen, maxlen, stat_len;
   logic [FT_W-1:0]   ft_min;

   rx_state_t         state;
   logic [CNT_W-1:0]  width_cnt, space_cnt;
   logic [CNT_W:0]    period;
   logic [LEN_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] shreg;
   logic              have_ldr, bad;
   logic              act, rise;
   logic [NUM_WIN-1:0] hit;

   logic              run_en, in_idle;
   logic              sym_end, free_end, msg_ok;
   logic              expect_ldr, take_ldr, data_hit, data_bit, bit_val;
   logic [THR_W-1:0]  ft_thr;

   ir_dec_regs #(
      .LEN_W(LEN_W), .FT_W(FT_W), .MINLEN_CAP(MINLEN_CAP), .MAXLEN_CAP(MAXLEN_CAP),
      .NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .ctrl(ctrl), .win(win), .minlen(minlen), .maxlen(maxlen),
      .ft_min(ft_min), .msg_ok(msg_ok), .msg_len(bit_cnt), .msg_data(shreg),
      .valid(data_valid), .stat_len(stat_len)
   );

   ir_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw(ir_in), .pol_inv(ctrl.pol_inv),
      .act(act), .rise(rise)
   );

   assign period = (CNT_W+1)'(width_cnt) + (CNT_W+1)'(space_cnt);

   // Window bank: entry 0 is the leader, entries 1..4 are data symbols.
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
      localparam int WS = (i == 0) ? LDR_SHIFT : DAT_W_SHIFT;
      localparam int PS = (i == 0) ? LDR_SHIFT : DAT_PD_SHIFT;
      ir_win_match #(.CNT_W(CNT_W), .W_SHIFT(WS), .P_SHIFT(PS)) u_win (
         .width(width_cnt), .period(period), .win(win[i]), .hit(hit[i])
      );
   end

   assign run_en     = ctrl.run;
   assign in_idle    = (state == ST_IDLE);
   assign ft_thr     = {ft_min, {FT_SHIFT{1'b0}}};
   assign sym_end    = (state == ST_SPACE) && act;
   assign free_end   = (state == ST_SPACE) && !act && (space_cnt >= CNT_W'(ft_thr));

   assign expect_ldr = ctrl.ldr_en && !have_ldr;
   assign take_ldr   = expect_ldr && hit[0];
   assign data_hit   = !expect_ldr && (|hit[NUM_WIN-1:1]);
   // Priority: data 0, data 1, alternate 0, alternate 1.
   assign data_bit   = hit[1] ? 1'b0 : hit[2] ? 1'b1 : hit[3] ? 1'b0 : 1'b1;
   assign bit_val    = data_bit ^ ctrl.bit_inv;

   assign msg_ok = free_end && !bad && (!ctrl.ldr_en || have_ldr)
                   && (bit_cnt >= minlen) && (bit_cnt <= maxlen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         width_cnt <= '0;
         space_cnt <= '0;
         bit_cnt   <= '0;
         shreg     <= '0;
         have_ldr  <= 1'b0;
         bad       <= 1'b0;
      end else if (!ctrl.run) begin
         state     <= ST_IDLE;
         width_cnt <= '0;
         space_cnt <= '0;
         bit_cnt   <= '0;
         have_ldr  <= 1'b0;
         bad       <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (rise) begin
                  state     <= ST_PULSE;
                  width_cnt <= CNT_W'(1);
                  space_cnt <= '0;
                  bit_cnt   <= '0;
                  shreg     <= '0;
                  have_ldr  <= 1'b0;
                  bad       <= 1'b0;
               end
            end
            ST_PULSE: begin
               if (act) begin
                  if (!(&width_cnt)) width_cnt <= width_cnt + CNT_W'(1);
               end else begin
                  space_cnt <= CNT_W'(1);
                  state     <= ST_SPACE;
               end
            end
            ST_SPACE: begin
               if (act) begin
                  if (!bad) begin
                     if (!(take_ldr || data_hit)) begin
                        bad <= 1'b1;
                     end else if (take_ldr) begin
                        have_ldr <= 1'b1;
                     end else begin
                        if (ctrl.lsb_first) begin
                           if (bit_cnt < LEN_W'(DATA_W)) shreg[bit_cnt[IDX_W-1:0]] <= bit_val;
                        end else begin
                           shreg <= {shreg[DATA_W-2:0], bit_val};
                        end
                        if (!(&bit_cnt)) bit_cnt <= bit_cnt + LEN_W'(1);
                     end
                  end
                  width_cnt <= CNT_W'(1);
                  space_cnt <= '0;
                  state     <= ST_PULSE;
               end else if (free_end) begin
                  state <= ST_IDLE;
               end else if (!(&space_cnt)) begin
                  space_cnt <= space_cnt + CNT_W'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ir_pulse_decoder_chk.sv
module ir_pulse_decoder_chk
   import ir_dec_pkg::*;
#(
   parameter int LEN_W      = 7,
   parameter int MINLEN_CAP = 30,
   parameter int MAXLEN_CAP = 48
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             in_idle,
   input logic             valid,
   input logic             msg_ok,
   input logic [LEN_W-1:0] stat_len,
   input logic [LEN_W-1:0] minlen,
   input logic [LEN_W-1:0] maxlen,
   input logic             reg_wr,
   input logic [3:0]       reg_addr,
   input logic [31:0]      reg_wdata
);
   logic clear_req, stat_wr;
   assign stat_wr   = reg_wr && (reg_addr == 4'(A_STAT));
   assign clear_req = stat_wr && !reg_wdata[0];

   assert_len_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> (stat_len >= $past(minlen)) && (stat_len <= $past(maxlen)));

   assert_len_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (minlen <= LEN_W'(MINLEN_CAP)) && !minlen[0] && (maxlen <= LEN_W'(MAXLEN_CAP)) && !maxlen[0]);

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_req && !msg_ok) |=> !valid);

   assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !clear_req) |=> valid);

   assert_set_needs_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid) |-> $past(run_en));

   assert_idle_when_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> in_idle);
endmodule

bind ir_pulse_decoder ir_pulse_decoder_chk #(
   .LEN_W(LEN_W), .MINLEN_CAP(MINLEN_CAP), .MAXLEN_CAP(MAXLEN_CAP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .in_idle(in_idle),
   .valid(data_valid), .msg_ok(msg_ok), .stat_len(stat_len),
   .minlen(minlen), .maxlen(maxlen),
   .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/ir_pulse_decoder_test.sv
module ir_pulse_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir_in = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        data_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   localparam int CTRL_STD = 32'h15; // run, lsb-first, leader required
   localparam logic [31:0] FRAME_STD = (32'd20 << 16) | (32'd32 << 8) | 32'd4;

   ir_pulse_decoder uut (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .data_valid(data_valid)
   );

   always #4 clk = ~clk;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic pair(input int w, input int s, input logic lvl);
      ir_in = lvl;
      repeat (w) @(negedge clk);
      ir_in = ~lvl;
      repeat (s) @(negedge clk);
   endtask

   task automatic send_msg(input logic [63:0] bits, input int n, input bit ldr,
                           input bit alt, input logic lvl);
      @(negedge clk);
      if (ldr) pair(160, 80, lvl);
      for (int i = 0; i < n; i++) begin
         if (alt) pair(30, bits[i] ? 30 : 10, lvl);
         else     pair(10, bits[i] ? 30 : 10, lvl);
      end
      ir_in = lvl;
      repeat (10) @(negedge clk);
      ir_in = ~lvl;
   endtask

   function automatic logic [63:0] exp_lsb(input logic [63:0] b, input int n, input bit inv);
      logic [63:0] r = '0;
      for (int i = 0; i < n; i++) r[i] = b[i] ^ inv;
      return r;
   endfunction

   function automatic logic [63:0] exp_msb(input logic [63:0] b, input int n, input bit inv);
      logic [63:0] r = '0;
      for (int i = 0; i < n; i++) r = {r[62:0], b[i] ^ inv};
      return r;
   endfunction

   task automatic clear_status();
      wr(1, 32'h0);
   endtask

   task automatic expect_msg(input string req, input bit ok, input int n,
                             input logic [63:0] exp);
      logic [31:0] st, lo, hi;
      repeat (230) @(negedge clk);
      rd(1, st);
      check(req, "valid flag", 64'(st[0]), 64'(ok));
      check(req, "data_valid port", 64'(data_valid), 64'(ok));
      if (ok) begin
         rd(8, lo); rd(9, hi);
         check(req, "length", 64'(st[14:8]), 64'(n));
         check(req, "data", {hi, lo}, exp);
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      for (int a = 0; a < 10; a++) begin
         rd(a, d);
         check("R1", $sformatf("reg %0d after reset", a), 64'(d), 64'h0);
      end
      check("R1", "data_valid after reset", 64'(data_valid), 64'h0);
   endtask

   task automatic setup();
      wr(2, {8'd17, 8'd13, 8'd12, 8'd8});
      wr(3, {8'd12, 8'd8,  8'd12, 8'd8});
      wr(4, {8'd23, 8'd17, 8'd12, 8'd8});
      wr(5, {8'd23, 8'd17, 8'd34, 8'd26});
      wr(6, {8'd33, 8'd27, 8'd34, 8'd26});
      wr(7, FRAME_STD);
      wr(0, CTRL_STD);
   endtask

   task automatic t_basic();
      logic [63:0] b = 64'hA5C3;
      clear_status();
      send_msg(b, 16, 1'b1, 1'b0, 1'b1);
      expect_msg("R2", 1'b1, 16, exp_lsb(b, 16, 1'b0));
   endtask

   task automatic t_order();
      logic [63:0] b = 64'h0B2D;
      wr(0, 32'h11);
      clear_status();
      send_msg(b, 12, 1'b1, 1'b0, 1'b1);
      expect_msg("R3", 1'b1, 12, exp_msb(b, 12, 1'b0));
      wr(0, CTRL_STD);
   endtask

   task automatic t_invert();
      logic [63:0] b = 64'h3C5;
      wr(0, 32'h1D);
      clear_status();
      send_msg(b, 10, 1'b1, 1'b0, 1'b1);
      expect_msg("R4", 1'b1, 10, exp_lsb(b, 10, 1'b1));
      wr(0, CTRL_STD);
   endtask

   task automatic t_polarity();
      logic [63:0] b = 64'h5A;
      wr(0, 32'h0);
      ir_in = 1'b1;
      repeat (5) @(negedge clk);
      wr(0, 32'h17);
      clear_status();
      send_msg(b, 8, 1'b1, 1'b0, 1'b0);
      expect_msg("R5", 1'b1, 8, exp_lsb(b, 8, 1'b0));
      wr(0, 32'h0);
      ir_in = 1'b0;
      repeat (5) @(negedge clk);
      wr(0, CTRL_STD);
   endtask

   task automatic t_alt();
      logic [63:0] b = 64'h96;
      clear_status();
      send_msg(b, 8, 1'b1, 1'b1, 1'b1);
      expect_msg("R6", 1'b1, 8, exp_lsb(b, 8, 1'b0));
   endtask

   task automatic t_bad_symbol();
      logic [63:0] b = 64'h3F;
      clear_status();
      @(negedge clk);
      pair(160, 80, 1'b1);
      for (int i = 0; i < 3; i++) pair(10, 10, 1'b1);
      pair(10, 60, 1'b1); // width fits, period fits nothing
      for (int i = 0; i < 4; i++) pair(10, 30, 1'b1);
      ir_in = 1'b1; repeat (10) @(negedge clk); ir_in = 1'b0;
      expect_msg("R7", 1'b0, 0, 64'h0);
      send_msg(b, 6, 1'b1, 1'b0, 1'b1);
      expect_msg("R7", 1'b1, 6, exp_lsb(b, 6, 1'b0));
   endtask

   task automatic t_length();
      logic [63:0] b = 64'h2_1234_5678;
      clear_status();
      send_msg(b, 2, 1'b1, 1'b0, 1'b1);
      expect_msg("R8", 1'b0, 0, 64'h0);
      send_msg(b, 4, 1'b1, 1'b0, 1'b1);
      expect_msg("R8", 1'b1, 4, exp_lsb(b, 4, 1'b0));
      clear_status();
      send_msg(b, 32, 1'b1, 1'b0, 1'b1);
      expect_msg("R8", 1'b1, 32, exp_lsb(b, 32, 1'b0));
      clear_status();
      send_msg(b, 34, 1'b1, 1'b0, 1'b1);
      expect_msg("R8", 1'b0, 0, 64'h0);
   endtask

   task automatic t_fields();
      logic [31:0] d;
      wr(7, (32'd20 << 16) | (32'd60 << 8) | 32'd31);
      rd(7, d);
      check("R9", "minlen capped", 64'(d[4:0]), 64'd30);
      check("R9", "maxlen capped", 64'(d[13:8]), 64'd48);
      check("R9", "free time kept", 64'(d[28:16]), 64'd20);
      wr(7, (32'd20 << 16) | (32'd17 << 8) | 32'd7);
      rd(7, d);
      check("R9", "minlen rounded down", 64'(d[4:0]), 64'd6);
      check("R9", "maxlen rounded up", 64'(d[13:8]), 64'd18);
      wr(7, FRAME_STD);
   endtask

   task automatic t_leader();
      logic [63:0] b = 64'hC3;
      clear_status();
      send_msg(b, 8, 1'b0, 1'b0, 1'b1);
      expect_msg("R10", 1'b0, 0, 64'h0);
      wr(0, 32'h05);
      send_msg(b, 8, 1'b0, 1'b0, 1'b1);
      expect_msg("R10", 1'b1, 8, exp_lsb(b, 8, 1'b0));
      wr(0, CTRL_STD);
   endtask

   task automatic t_status();
      logic [31:0] d;
      clear_status();
      send_msg(64'h9, 4, 1'b1, 1'b0, 1'b1);
      repeat (230) @(negedge clk);
      wr(1, 32'h1);
      rd(1, d);
      check("R11", "valid kept after writing 1", 64'(d[0]), 64'h1);
      wr(1, 32'h0);
      rd(1, d);
      check("R11", "valid cleared by writing 0", 64'(d[0]), 64'h0);
      wr(1, 32'h1);
      rd(1, d);
      check("R11", "writing 1 does not set", 64'(d[0]), 64'h0);
      check("R11", "port follows", 64'(data_valid), 64'h0);
   endtask

   task automatic t_off();
      clear_status();
      wr(0, 32'h0);
      send_msg(64'hF0, 8, 1'b1, 1'b0, 1'b1);
      expect_msg("R12", 1'b0, 0, 64'h0);
      wr(0, CTRL_STD);
   endtask

   task automatic t_free_time();
      logic [31:0] d;
      clear_status();
      send_msg(64'h6, 4, 1'b1, 1'b0, 1'b1);
      repeat (100) @(negedge clk);
      rd(1, d);
      check("R13", "not valid before free time", 64'(d[0]), 64'h0);
      repeat (100) @(negedge clk);
      rd(1, d);
      check("R13", "valid after free time", 64'(d[0]), 64'h1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      setup();
      t_basic();
      t_order();
      t_invert();
      t_polarity();
      t_alt();
      t_bad_symbol();
      t_length();
      t_fields();
      t_leader();
      t_status();
      t_off();
      t_free_time();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule